// File: doc/BRIEF.md
# Descriptor-Driven Destination Address Sequencer

This block supplies destination addresses to a write engine that drains captured data into system memory. Before any transfer, software fills a small table of buffer descriptors through a register-style write port. Each descriptor names a byte start address, a length in data words, and what to do once that length has been written. A start strobe activates descriptor 0. From then on, the block presents the current address and moves on by one word each time the engine reports an accepted transfer.

When a buffer's last word is accepted, the block pulses an interrupt in that same cycle. It then carries out the descriptor's completion action:
- **Restart**: begin the same buffer again at its start address.
- **Chain**: step to the next descriptor with no idle cycle in between. Descriptor indices wrap back to 0 after the last one.
- **Halt**: stop, and raise the suspended flag until the next start strobe.

Chaining with two descriptors gives ping-pong capture, so one buffer fills while software reads the other. Chaining with more descriptors gives a longer ring. A descriptor with a word count of zero issues no address and completes at once.

Top module: `chain_addr_seq`

## Requirements
- R1: While reset is held and after it is released, with no start strobe yet: `suspended` is 1, `addr_valid` is 0 and `irq` is 0.
- R2: A cycle with `cfg_we` high stores `cfg_addr`, `cfg_count` and `cfg_action` into descriptor `cfg_idx`. The action codes are: 2'b00 restart the same buffer, 2'b01 chain to the next descriptor, 2'b10 halt. The code 2'b11 behaves as halt.
- R3: The cycle after `start` is high, descriptor 0 is active. If its count is nonzero, then `addr_valid` is 1, `suspended` is 0 and `cur_addr` equals its start address. `start` overrides any transfer or completion in the same cycle, and an `adv` in that cycle is discarded.
- R4: An `adv` while `addr_valid` is high, and that is not the buffer's last word, makes `cur_addr` 4 larger in the next cycle. An `adv` while `addr_valid` is low changes nothing.
- R5: `irq` is high for exactly the cycles in which `adv` accepts the count-th word of the active buffer (`adv` high, `addr_valid` high, `start` low). It is never high otherwise.
- R6: With action 2'b00, the cycle after the last word shows the same descriptor's start address again, with its full count available.
- R7: With action 2'b01, the cycle after the last word shows the next descriptor's start address with `addr_valid` still high. The descriptor after the last index is descriptor 0.
- R8: With action 2'b10 or 2'b11, the cycle after the last word has `suspended` at 1 and `addr_valid` at 0. It stays so, ignoring `adv`, until `start`.
- R9: Entering a descriptor whose count is zero gives one cycle with `addr_valid` 0, `suspended` 0 and no `irq`. Then its action applies: chain moves on, while restart or halt suspends. A ring of only zero-count chained descriptors suspends after visiting each descriptor once.
- R10: Writing the table while a buffer is active does not alter that buffer's remaining addresses, count or action. The new contents take effect the next time the descriptor is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_idx | input | IDX_W (3) | Descriptor index to write |
| cfg_addr | input | ADDR_W (32) | Buffer start byte address |
| cfg_count | input | CNT_W (16) | Buffer length in words |
| cfg_action | input | 2 | Completion action code |
| start | input | 1 | Activate descriptor 0 and clear the halted state |
| adv | input | 1 | Write engine accepted the word at `cur_addr` |
| cur_addr | output | ADDR_W (32) | Current destination byte address |
| addr_valid | output | 1 | `cur_addr` is a live address |
| suspended | output | 1 | Sequencer is halted |
| irq | output | 1 | Buffer-complete pulse, coincident with the last word |

## Verification
The hardest situation to reach is a chain of several zero-count descriptors sitting between live buffers. This includes the case where every descriptor in the ring is empty, which must end in a halt rather than loop. A directed case fills the whole table with chained zero-length entries. Random tables draw counts from 0 to 4 with all four action codes, so empty entries often appear between active ones and next to index wrap-around. Start strobes dropped at random land mid-buffer and on last words.

// File: rtl/chain_seq_pkg.sv
package chain_seq_pkg;

  typedef enum logic [1:0] {
    ACT_WRAP  = 2'b00,
    ACT_CHAIN = 2'b01,
    ACT_HALT  = 2'b10,
    ACT_RSVD  = 2'b11
  } end_act_e;

  typedef enum logic [1:0] {
    SQ_HALT = 2'b00,
    SQ_RUN  = 2'b01,
    SQ_SKIP = 2'b10
  } seq_state_e;

endpackage

// File: rtl/chain_rst_sync.sv
module chain_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/chain_desc_table.sv
module chain_desc_table #(
  parameter int N_DESC = 8,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  localparam int IDX_W = $clog2(N_DESC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_cnt,
  input  logic [1:0]        wr_act,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_cnt,
  output logic [1:0]        rd_act
);
  logic [ADDR_W-1:0] ent_addr [N_DESC];
  logic [CNT_W-1:0]  ent_cnt  [N_DESC];
  logic [1:0]        ent_act  [N_DESC];
  logic [N_DESC-1:0] ent_we;

  for (genvar g = 0; g < N_DESC; g++) begin : g_we
    assign ent_we[g] = wr_en && (wr_idx == IDX_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_DESC; i++) begin
        ent_addr[i] <= '0;
        ent_cnt[i]  <= '0;
        ent_act[i]  <= 2'b10;
      end
    end else begin
      for (int i = 0; i < N_DESC; i++) begin
        if (ent_we[i]) begin
          ent_addr[i] <= wr_addr;
          ent_cnt[i]  <= wr_cnt;
          ent_act[i]  <= wr_act;
        end
      end
    end
  end

  assign rd_addr = ent_addr[rd_idx];
  assign rd_cnt  = ent_cnt[rd_idx];
  assign rd_act  = ent_act[rd_idx];

  // R2: a write lands in the addressed entry
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ent_addr[$past(wr_idx)] == $past(wr_addr)) &&
              (ent_cnt[$past(wr_idx)]  == $past(wr_cnt)) &&
              (ent_act[$past(wr_idx)]  == $past(wr_act)));
endmodule

// File: rtl/chain_seq_ctrl.sv
module chain_seq_ctrl
  import chain_seq_pkg::*;
#(
  parameter int N_DESC     = 8,
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W     = $clog2(N_DESC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              adv,
  input  logic [ADDR_W-1:0] tbl_addr,
  input  logic [CNT_W-1:0]  tbl_cnt,
  input  logic [1:0]        tbl_act,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              addr_valid,
  output logic              suspended,
  output logic              irq
);
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(N_DESC - 1);
  localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(WORD_BYTES);
  localparam logic [CNT_W-1:0]  ONE      = CNT_W'(1);

  seq_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d, skc_q, skc_d, next_idx, tgt;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic [1:0]        act_q, act_d;
  logic              enter, last_word;

  assign next_idx  = (idx_q == LAST_IDX) ? '0 : idx_q + IDX_W'(1);
  assign last_word = (state_q == SQ_RUN) && adv && !start && (rem_q == ONE);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    addr_d  = addr_q;
    rem_d   = rem_q;
    act_d   = act_q;
    skc_d   = skc_q;
    enter   = 1'b0;
    tgt     = idx_q;
    if (start) begin
      enter = 1'b1;
      tgt   = '0;
      skc_d = '0;
    end else begin
      case (state_q)
        SQ_RUN: begin
          if (adv) begin
            if (rem_q == ONE) begin
              case (act_q)
                ACT_WRAP:  begin enter = 1'b1; tgt = idx_q;    end
                ACT_CHAIN: begin enter = 1'b1; tgt = next_idx; end
                default:   state_d = SQ_HALT;
              endcase
            end else begin
              addr_d = addr_q + STEP;
              rem_d  = rem_q - ONE;
            end
          end
        end
        SQ_SKIP: begin
          if ((act_q == ACT_CHAIN) && (skc_q != LAST_IDX)) begin
            enter = 1'b1;
            tgt   = next_idx;
            skc_d = skc_q + IDX_W'(1);
          end else begin
            state_d = SQ_HALT;
          end
        end
        default: ;
      endcase
    end
    if (enter) begin
      idx_d  = tgt;
      addr_d = tbl_addr;
      rem_d  = tbl_cnt;
      act_d  = tbl_act;
      if (tbl_cnt != '0) begin
        state_d = SQ_RUN;
        skc_d   = '0;
      end else begin
        state_d = SQ_SKIP;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_HALT;
      idx_q   <= '0;
      addr_q  <= '0;
      rem_q   <= '0;
      act_q   <= 2'b00;
      skc_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      addr_q  <= addr_d;
      rem_q   <= rem_d;
      act_q   <= act_d;
      skc_q   <= skc_d;
    end
  end

  assign rd_idx     = tgt;
  assign cur_addr   = addr_q;
  assign addr_valid = (state_q == SQ_RUN);
  assign suspended  = (state_q == SQ_HALT);
  assign irq        = last_word;

  assert_start_loads_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (idx_q == '0) && !suspended);

  assert_run_has_words_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_RUN) |-> (rem_q != '0));

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && adv && !start && (rem_q != ONE)) |=>
      addr_valid && (cur_addr == $past(cur_addr) + STEP));

  assert_idle_adv_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_valid && !start && (state_q == SQ_HALT)) |=> $stable(cur_addr));

  assert_irq_with_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (addr_valid && adv && !start));

  assert_wrap_same_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && (act_q == ACT_WRAP)) |=> (idx_q == $past(idx_q)));

  assert_chain_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && (act_q == ACT_CHAIN)) |=>
      (idx_q == (($past(idx_q) == LAST_IDX) ? '0 : $past(idx_q) + IDX_W'(1))));

  assert_halt_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && act_q[1]) |=> suspended);

  assert_halt_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && !start) |=> suspended);

  assert_skip_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_SKIP) |-> ((rem_q == '0) && !irq));
endmodule

// File: rtl/chain_addr_seq.sv
module chain_addr_seq #(
  parameter int N_DESC     = 8,
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W     = $clog2(N_DESC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic [1:0]        cfg_action,
  input  logic              start,
  input  logic              adv,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              addr_valid,
  output logic              suspended,
  output logic              irq
);
  logic              rst_int_n;
  logic [IDX_W-1:0]  rd_idx;
  logic [ADDR_W-1:0] rd_addr;
  logic [CNT_W-1:0]  rd_cnt;
  logic [1:0]        rd_act;

  chain_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  chain_desc_table #(
    .N_DESC (N_DESC),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) u_table (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (cfg_we),
    .wr_idx  (cfg_idx),
    .wr_addr (cfg_addr),
    .wr_cnt  (cfg_count),
    .wr_act  (cfg_action),
    .rd_idx  (rd_idx),
    .rd_addr (rd_addr),
    .rd_cnt  (rd_cnt),
    .rd_act  (rd_act)
  );

  chain_seq_ctrl #(
    .N_DESC     (N_DESC),
    .ADDR_W     (ADDR_W),
    .CNT_W      (CNT_W),
    .WORD_BYTES (WORD_BYTES)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (start),
    .adv        (adv),
    .tbl_addr   (rd_addr),
    .tbl_cnt    (rd_cnt),
    .tbl_act    (rd_act),
    .rd_idx     (rd_idx),
    .cur_addr   (cur_addr),
    .addr_valid (addr_valid),
    .suspended  (suspended),
    .irq        (irq)
  );

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> (suspended && !addr_valid && !irq));
endmodule

// File: tb/chain_addr_seq_tb.sv
`timescale 1ns/1ps
module chain_addr_seq_tb;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_idx;
  logic [31:0] cfg_addr;
  logic [15:0] cfg_count;
  logic [1:0]  cfg_action;
  logic        start, adv;
  logic [31:0] cur_addr;
  logic        addr_valid, suspended, irq;

  int n_chk = 0;
  int n_fail = 0;

  // bench copy of the table and reference state
  logic [31:0] t_addr [N];
  logic [15:0] t_cnt  [N];
  logic [1:0]  t_act  [N];
  int          m_mode;   // 0 halted, 1 running, 2 empty-entry cycle
  int          m_idx, m_skc;
  logic [31:0] m_addr;
  logic [15:0] m_rem;
  logic [1:0]  m_act;

  always #2.5 clk = ~clk;

  chain_addr_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_addr(cfg_addr), .cfg_count(cfg_count), .cfg_action(cfg_action),
    .start(start), .adv(adv), .cur_addr(cur_addr), .addr_valid(addr_valid),
    .suspended(suspended), .irq(irq)
  );

  task automatic chk(input logic [31:0] act_v, input logic [31:0] exp_v,
                     input string tag, input string what);
    n_chk++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act_v, exp_v, $time);
    end
  endtask

  task automatic m_enter(input int i);
    m_idx  = i;
    m_addr = t_addr[i];
    m_rem  = t_cnt[i];
    m_act  = t_act[i];
    if (m_rem != 0) begin m_mode = 1; m_skc = 0; end
    else m_mode = 2;
  endtask

  task automatic m_step(input logic a, input logic s);
    if (s) begin
      m_skc = 0;
      m_enter(0);
    end else if (m_mode == 1 && a) begin
      if (m_rem == 1) begin
        if (m_act == 2'b00)      m_enter(m_idx);
        else if (m_act == 2'b01) m_enter((m_idx + 1) % N);
        else                     m_mode = 0;
      end else begin
        m_addr = m_addr + 4;
        m_rem  = m_rem - 1;
      end
    end else if (m_mode == 2) begin
      if (m_act == 2'b01 && m_skc != N - 1) begin
        m_skc++;
        m_enter((m_idx + 1) % N);
      end else m_mode = 0;
    end
  endtask

  // one cycle: drive at the falling edge, check, then step the model at the rising edge
  task automatic cyc(input logic a, input logic s, input string tag);
    adv = a;
    start = s;
    #1;
    chk(32'(addr_valid), 32'(m_mode == 1), tag, "addr_valid");
    chk(32'(suspended), 32'(m_mode == 0), tag, "suspended");
    chk(32'(irq), 32'(m_mode == 1 && a && !s && m_rem == 1), tag, "irq");
    if (m_mode == 1) chk(cur_addr, m_addr, tag, "cur_addr");
    @(posedge clk);
    m_step(a, s);
    if (cfg_we) begin
      t_addr[cfg_idx] = cfg_addr;
      t_cnt[cfg_idx]  = cfg_count;
      t_act[cfg_idx]  = cfg_action;
    end
    @(negedge clk);
    cfg_we = 1'b0;
    adv = 1'b0;
    start = 1'b0;
  endtask

  task automatic wload(input int i, input logic [31:0] a, input logic [15:0] c,
                       input logic [1:0] ac, input string tag);
    cfg_we = 1'b1;
    cfg_idx = 3'(i);
    cfg_addr = a;
    cfg_count = c;
    cfg_action = ac;
    cyc(1'b0, 1'b0, tag);
  endtask

  task automatic run(input int n, input string tag);
    for (int k = 0; k < n; k++) cyc(1'b1, 1'b0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20117));
    for (int i = 0; i < N; i++) begin t_addr[i] = '0; t_cnt[i] = '0; t_act[i] = 2'b10; end
    m_mode = 0; m_idx = 0; m_skc = 0; m_addr = '0; m_rem = '0; m_act = '0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_addr = '0; cfg_count = '0;
    cfg_action = '0; start = 1'b0; adv = 1'b0;
    repeat (3) @(negedge clk);
    chk(32'(suspended), 32'd1, "R1", "suspended in reset");
    chk(32'(addr_valid), 32'd0, "R1", "addr_valid in reset");
    chk(32'(irq), 32'd0, "R1", "irq in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 / R4: adv before any start is ignored
    run(3, "R1");

    // R7: chained ring with an empty entry, running through index wrap-around
    for (int i = 0; i < N; i++)
      wload(i, 32'h1000 * (i + 1), 16'((i % 3) + 1), 2'b01, "R2");
    wload(2, 32'h3000, 16'd0, 2'b01, "R9");
    cyc(1'b0, 1'b1, "R3");
    run(40, "R7");
    // R3: restart in the middle of a buffer
    cyc(1'b1, 1'b1, "R3");
    run(2, "R3");

    // R6: restart same buffer
    wload(0, 32'h0000_8000, 16'd3, 2'b00, "R6");
    cyc(1'b0, 1'b1, "R6");
    run(10, "R6");
    // count of one restarts every word
    wload(0, 32'h0000_8100, 16'd1, 2'b00, "R6");
    cyc(1'b0, 1'b1, "R6");
    run(4, "R6");

    // R8: halt code and reserved code, then adv ignored
    wload(0, 32'h0000_9000, 16'd2, 2'b10, "R8");
    cyc(1'b0, 1'b1, "R8");
    run(6, "R8");
    wload(0, 32'h0000_9100, 16'd2, 2'b11, "R2");
    cyc(1'b0, 1'b1, "R2");
    run(6, "R8");

    // R9: every entry empty and chained
    for (int i = 0; i < N; i++) wload(i, 32'h40 * i, 16'd0, 2'b01, "R9");
    cyc(1'b0, 1'b1, "R9");
    run(12, "R9");
    // empty entry that restarts or halts suspends
    wload(0, 32'h0, 16'd0, 2'b00, "R9");
    cyc(1'b0, 1'b1, "R9");
    run(3, "R9");

    // R10: rewrite the active descriptor mid-buffer
    wload(0, 32'h0000_0100, 16'd4, 2'b00, "R10");
    cyc(1'b0, 1'b1, "R10");
    run(2, "R10");
    wload(0, 32'h0000_0900, 16'd2, 2'b10, "R10");
    run(8, "R10");

    // random tables, random acceptance, occasional restarts
    for (int r = 0; r < 40; r++) begin
      for (int i = 0; i < N; i++)
        wload(i, $urandom() & 32'hFFFF_FFFC, 16'($urandom_range(0, 4)),
              2'($urandom_range(0, 3)), "R2");
      cyc(1'b0, 1'b1, "R3");
      for (int k = 0; k < 300; k++)
        cyc(1'($urandom_range(0, 9) < 7), 1'($urandom_range(0, 99) == 0), "R5");
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule